// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for one video stream from a pixel clock. A horizontal counter walks across each line and a vertical counter walks down the frame. A set of comparators turns the two counts into six registered strobes: horizontal blank, horizontal sync, vertical blank, vertical sync, active video and active chroma.

Ten timing values set the frame geometry. Each value has its own source-select bit, which picks either the value on a detected-timing bus or the value a host wrote to an override bus. So a host can correct a single detected value and keep the rest. The selected values are copied into shadow registers only at a frame boundary, which means a frame always finishes with the geometry it began with.

Each output has its own polarity. The chroma strobe can be thinned for 4:2:0 sampling by skipping alternate lines, alternate pixels, or both. At build time, generation as a whole can be removed, and any single output can be tied off.

Top module: `raster_timing_gen`

## Requirements
- R1: The horizontal count runs 0 to hTotal-1 and then returns to 0. On each such return the vertical count advances by one, and it returns to 0 after line vTotal-1.
- R2: Generation runs only when build parameter GEN_ENABLE is 1 and at least one of genEnA and genEnB is high. While it is not running, both counts sit at 0 and every output sits at its inactive level, which is the inverse of its polarity bit.
- R3: The polarity bit order is bit0 hBlank, bit1 hSync, bit2 vBlank, bit3 vSync, bit4 activeVideo, bit5 activeChroma. A polarity bit of 1 makes that output active-high and a bit of 0 makes it active-low. Polarity applies from the next clock.
- R4: hBlank is active when hCount >= hActive. hSync is active when hSyncStart <= hCount < hSyncEnd.
- R5: vSync is active for whole lines with vSyncStart <= vCount < vSyncEnd.
- R6: vBlank turns on at horizontal position vbHStart of line vActive. It stays on until horizontal position vbHEnd of line vTotal-1, where it turns off. With vbHEnd = hTotal-1, vBlank drops exactly one clock before hBlank drops at the end of the frame.
- R7: activeVideo is active when hCount < hActive and vCount < vActive.
- R8: When chromaLineSkip is 1, activeChroma is active only on even-numbered active lines. When it is 0, activeChroma follows activeVideo on every line.
- R9: When chromaPixSkip is 1, activeChroma is active only at even horizontal positions. When it is 0, no pixel is skipped.
- R10: Timing slot i occupies bits [i*CNT_W +: CNT_W] of both buses, and srcSel[i]=1 takes that slot from hostTiming while 0 takes it from detTiming. The slot order is 0 hTotal, 1 hActive, 2 hSyncStart, 3 hSyncEnd, 4 vTotal, 5 vActive, 6 vSyncStart, 7 vSyncEnd, 8 vbHStart, 9 vbHEnd.
- R11: Changes to the timing buses or to srcSel while running take effect only after the last pixel of the current frame. While idle, they take effect at once.
- R12: If bit i of build parameter OUT_MASK is 0, output i is held at its inactive level at all times.
- R13: Every output is registered. The outputs during clock n+1 reflect the counts during clock n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| genEnA | input | 1 | Generation enable, first control bit |
| genEnB | input | 1 | Generation enable, second control bit |
| polarity | input | 6 | Per-output polarity, 1 = active-high |
| chromaLineSkip | input | 1 | Chroma on alternate lines only |
| chromaPixSkip | input | 1 | Chroma on alternate pixels only |
| srcSel | input | 10 | Per-value source select, 1 = host |
| detTiming | input | 10*CNT_W | Detected timing values |
| hostTiming | input | 10*CNT_W | Host override timing values |
| hBlank | output | 1 | Horizontal blank |
| hSync | output | 1 | Horizontal sync |
| vBlank | output | 1 | Vertical blank |
| vSync | output | 1 | Vertical sync |
| activeVideo | output | 1 | Active video |
| activeChroma | output | 1 | Active chroma |

## Verification
The bench goes after the last pixel of the frame. There vBlank must drop one clock ahead of hBlank, and a comparator that is off by one there would move the two edges together or two clocks apart. It also changes the override bus and srcSel in the middle of a frame: a design without frame-aligned shadowing would tear the current frame. Chroma decimation is checked on line and pixel parity, where an inverted parity test would light the odd lines. Enables are dropped in the middle of a line, and polarities and tied-off outputs are varied, to catch counters that do not return to zero and idle outputs left at the wrong level.

// File: rtl/raster_timing_pkg.sv
package raster_timing_pkg;
  localparam int NUM_VALS = 10;
  localparam int NUM_OUTS = 6;

  localparam int IX_HTOTAL = 0;
  localparam int IX_HACT   = 1;
  localparam int IX_HSS    = 2;
  localparam int IX_HSE    = 3;
  localparam int IX_VTOTAL = 4;
  localparam int IX_VACT   = 5;
  localparam int IX_VSS    = 6;
  localparam int IX_VSE    = 7;
  localparam int IX_VBHS   = 8;
  localparam int IX_VBHE   = 9;

  localparam int OB_HBLANK = 0;
  localparam int OB_HSYNC  = 1;
  localparam int OB_VBLANK = 2;
  localparam int OB_VSYNC  = 3;
  localparam int OB_AVID   = 4;
  localparam int OB_ACHROMA = 5;

  typedef struct packed {
    logic run;
    logic frameEnd;
    logic load;
  } ctrlStrobes_t;
endpackage

// File: rtl/raster_timing_ctrl.sv
module raster_timing_ctrl
  import raster_timing_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter bit GEN_ENABLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             genEnA,
  input  logic             genEnB,
  input  logic [CNT_W-1:0] hTotal,
  input  logic [CNT_W-1:0] vTotal,
  output logic [CNT_W-1:0] hCnt,
  output logic [CNT_W-1:0] vCnt,
  output ctrlStrobes_t     strb
);
  logic [CNT_W-1:0] hLast;
  logic [CNT_W-1:0] vLast;
  logic lineEnd;

  assign hLast   = hTotal - CNT_W'(1);
  assign vLast   = vTotal - CNT_W'(1);
  assign lineEnd = hCnt >= hLast;

  always_comb begin
    strb.run      = GEN_ENABLE && (genEnA || genEnB);
    strb.frameEnd = strb.run && lineEnd && (vCnt >= vLast);
    strb.load     = !strb.run || strb.frameEnd;
  end

  always_ff @(posedge clk) begin
    if (rst || !strb.run) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (lineEnd) begin
      hCnt <= '0;
      vCnt <= (vCnt >= vLast) ? '0 : vCnt + CNT_W'(1);
    end else begin
      hCnt <= hCnt + CNT_W'(1);
    end
  end

  // R2: idle keeps both counters at zero
  a_r2_idle_count: assert property (@(posedge clk) disable iff (rst)
    !strb.run |=> (hCnt == '0) && (vCnt == '0));

  // R1: horizontal count stays inside the line
  a_r1_h_range: assert property (@(posedge clk) disable iff (rst)
    (strb.run && $past(strb.run) && hTotal != '0) |-> hCnt < hTotal);

  // R1: vertical count only moves on a line wrap
  a_r1_v_step: assert property (@(posedge clk) disable iff (rst)
    (strb.run && hCnt != '0) |-> $stable(vCnt));
endmodule

// File: rtl/raster_timing_dp.sv
module raster_timing_dp
  import raster_timing_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter logic [NUM_OUTS-1:0] OUT_MASK = '1,
  localparam int BUS_W = NUM_VALS * CNT_W
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobes_t        strb,
  input  logic [CNT_W-1:0]    hCnt,
  input  logic [CNT_W-1:0]    vCnt,
  input  logic [NUM_VALS-1:0] srcSel,
  input  logic [BUS_W-1:0]    detTiming,
  input  logic [BUS_W-1:0]    hostTiming,
  input  logic [NUM_OUTS-1:0] polarity,
  input  logic                chromaLineSkip,
  input  logic                chromaPixSkip,
  output logic [CNT_W-1:0]    hTotal,
  output logic [CNT_W-1:0]    vTotal,
  output logic [NUM_OUTS-1:0] outQ
);
  logic [BUS_W-1:0] muxed;
  logic [BUS_W-1:0] shadowQ;

  for (genvar i = 0; i < NUM_VALS; i++) begin : g_src
    assign muxed[i*CNT_W +: CNT_W] = srcSel[i] ? hostTiming[i*CNT_W +: CNT_W]
                                               : detTiming[i*CNT_W +: CNT_W];
  end

  always_ff @(posedge clk) begin
    if (rst || strb.load) shadowQ <= muxed;
  end

  logic [CNT_W-1:0] hAct, hsStart, hsEnd, vAct, vsStart, vsEnd, vbHs, vbHe, vLast;
  assign hTotal  = shadowQ[IX_HTOTAL*CNT_W +: CNT_W];
  assign hAct    = shadowQ[IX_HACT*CNT_W +: CNT_W];
  assign hsStart = shadowQ[IX_HSS*CNT_W +: CNT_W];
  assign hsEnd   = shadowQ[IX_HSE*CNT_W +: CNT_W];
  assign vTotal  = shadowQ[IX_VTOTAL*CNT_W +: CNT_W];
  assign vAct    = shadowQ[IX_VACT*CNT_W +: CNT_W];
  assign vsStart = shadowQ[IX_VSS*CNT_W +: CNT_W];
  assign vsEnd   = shadowQ[IX_VSE*CNT_W +: CNT_W];
  assign vbHs    = shadowQ[IX_VBHS*CNT_W +: CNT_W];
  assign vbHe    = shadowQ[IX_VBHE*CNT_W +: CNT_W];
  assign vLast   = vTotal - CNT_W'(1);

  logic [NUM_OUTS-1:0] actHi;
  logic vbOn, vbOff;

  always_comb begin
    vbOn  = (vCnt > vAct) || ((vCnt == vAct) && (hCnt >= vbHs));
    vbOff = (vCnt == vLast) && (hCnt >= vbHe);
    actHi[OB_HBLANK]  = hCnt >= hAct;
    actHi[OB_HSYNC]   = (hCnt >= hsStart) && (hCnt < hsEnd);
    actHi[OB_VBLANK]  = vbOn && !vbOff;
    actHi[OB_VSYNC]   = (vCnt >= vsStart) && (vCnt < vsEnd);
    actHi[OB_AVID]    = (hCnt < hAct) && (vCnt < vAct);
    actHi[OB_ACHROMA] = actHi[OB_AVID] && (!chromaLineSkip || !vCnt[0])
                        && (!chromaPixSkip || !hCnt[0]);
  end

  for (genvar i = 0; i < NUM_OUTS; i++) begin : g_out
    if (OUT_MASK[i]) begin : g_live
      always_ff @(posedge clk) begin
        if (rst || !strb.run) outQ[i] <= ~polarity[i];
        else                  outQ[i] <= actHi[i] ~^ polarity[i];
      end
    end else begin : g_tied
      always_ff @(posedge clk) outQ[i] <= ~polarity[i];

      // R12: a tied-off output always shows its inactive level
      a_r12_tied_off: assert property (@(posedge clk) disable iff (rst)
        !rst |=> outQ[i] == ~$past(polarity[i]));
    end
  end

  // R2: idle drives every output inactive
  a_r2_idle_out: assert property (@(posedge clk) disable iff (rst)
    !strb.run |=> outQ == ~$past(polarity));

  // R11: geometry holds for the whole frame
  a_r11_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    (strb.run && !strb.frameEnd) |=> $stable(shadowQ));
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_timing_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter bit GEN_ENABLE = 1'b1,
  parameter logic [5:0] OUT_MASK = 6'b111111
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      genEnA,
  input  logic                      genEnB,
  input  logic [5:0]                polarity,
  input  logic                      chromaLineSkip,
  input  logic                      chromaPixSkip,
  input  logic [9:0]                srcSel,
  input  logic [10*CNT_W-1:0]       detTiming,
  input  logic [10*CNT_W-1:0]       hostTiming,
  output logic                      hBlank,
  output logic                      hSync,
  output logic                      vBlank,
  output logic                      vSync,
  output logic                      activeVideo,
  output logic                      activeChroma
);
  ctrlStrobes_t strb;
  logic [CNT_W-1:0] hCnt, vCnt, hTotal, vTotal;
  logic [NUM_OUTS-1:0] outQ;

  raster_timing_ctrl #(.CNT_W(CNT_W), .GEN_ENABLE(GEN_ENABLE)) u_ctrl (
    .clk(clk), .rst(rst), .genEnA(genEnA), .genEnB(genEnB),
    .hTotal(hTotal), .vTotal(vTotal), .hCnt(hCnt), .vCnt(vCnt), .strb(strb)
  );

  raster_timing_dp #(.CNT_W(CNT_W), .OUT_MASK(OUT_MASK)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .hCnt(hCnt), .vCnt(vCnt),
    .srcSel(srcSel), .detTiming(detTiming), .hostTiming(hostTiming),
    .polarity(polarity), .chromaLineSkip(chromaLineSkip),
    .chromaPixSkip(chromaPixSkip), .hTotal(hTotal), .vTotal(vTotal),
    .outQ(outQ)
  );

  assign hBlank       = outQ[OB_HBLANK];
  assign hSync        = outQ[OB_HSYNC];
  assign vBlank       = outQ[OB_VBLANK];
  assign vSync        = outQ[OB_VSYNC];
  assign activeVideo  = outQ[OB_AVID];
  assign activeChroma = outQ[OB_ACHROMA];
endmodule

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;
  localparam int W = 12;
  localparam logic [5:0] MASK_B = 6'b010110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic genEnA = 1'b0, genEnB = 1'b0;
  logic [5:0] polarity = 6'h3F;
  logic chromaLineSkip = 1'b0, chromaPixSkip = 1'b0;
  logic [9:0] srcSel = '0;
  logic [10*W-1:0] detTiming, hostTiming;

  always #2 clk = ~clk;

  logic [5:0] oFull, oMask, oOff;
  logic hb0, hs0, vb0, vs0, av0, ac0;
  logic hb1, hs1, vb1, vs1, av1, ac1;
  logic hb2, hs2, vb2, vs2, av2, ac2;

  raster_timing_gen #(.CNT_W(W)) u_dut (
    .clk(clk), .rst(rst), .genEnA(genEnA), .genEnB(genEnB), .polarity(polarity),
    .chromaLineSkip(chromaLineSkip), .chromaPixSkip(chromaPixSkip), .srcSel(srcSel),
    .detTiming(detTiming), .hostTiming(hostTiming), .hBlank(hb0), .hSync(hs0),
    .vBlank(vb0), .vSync(vs0), .activeVideo(av0), .activeChroma(ac0));

  raster_timing_gen #(.CNT_W(W), .OUT_MASK(MASK_B)) u_dutMask (
    .clk(clk), .rst(rst), .genEnA(genEnA), .genEnB(genEnB), .polarity(polarity),
    .chromaLineSkip(chromaLineSkip), .chromaPixSkip(chromaPixSkip), .srcSel(srcSel),
    .detTiming(detTiming), .hostTiming(hostTiming), .hBlank(hb1), .hSync(hs1),
    .vBlank(vb1), .vSync(vs1), .activeVideo(av1), .activeChroma(ac1));

  raster_timing_gen #(.CNT_W(W), .GEN_ENABLE(1'b0)) u_dutOff (
    .clk(clk), .rst(rst), .genEnA(genEnA), .genEnB(genEnB), .polarity(polarity),
    .chromaLineSkip(chromaLineSkip), .chromaPixSkip(chromaPixSkip), .srcSel(srcSel),
    .detTiming(detTiming), .hostTiming(hostTiming), .hBlank(hb2), .hSync(hs2),
    .vBlank(vb2), .vSync(vs2), .activeVideo(av2), .activeChroma(ac2));

  assign oFull = {ac0, av0, vs0, vb0, hs0, hb0};
  assign oMask = {ac1, av1, vs1, vb1, hs1, hb1};
  assign oOff  = {ac2, av2, vs2, vb2, hs2, hb2};

  function automatic logic [10*W-1:0] packT(int ht, int ha, int hss, int hse, int vt,
                                            int va, int vss, int vse, int vbs, int vbe);
    int v[10];
    logic [10*W-1:0] r;
    v = '{ht, ha, hss, hse, vt, va, vss, vse, vbs, vbe};
    for (int i = 0; i < 10; i++) r[i*W +: W] = W'(v[i]);
    return r;
  endfunction

  // Reference model built from the requirements
  logic [W-1:0] mH, mV;
  logic [W-1:0] mSh [10];
  logic [5:0] expFull, expMask, expOff;

  function automatic logic [W-1:0] pick(int i);
    return srcSel[i] ? hostTiming[i*W +: W] : detTiming[i*W +: W];
  endfunction

  function automatic logic [5:0] hiOf(logic [W-1:0] h, logic [W-1:0] v);
    logic [5:0] r;
    logic on, off;
    on  = (v > mSh[5]) || (v == mSh[5] && h >= mSh[8]);
    off = (v == mSh[4] - 1) && (h >= mSh[9]);
    r[0] = h >= mSh[1];
    r[1] = h >= mSh[2] && h < mSh[3];
    r[2] = on && !off;
    r[3] = v >= mSh[6] && v < mSh[7];
    r[4] = h < mSh[1] && v < mSh[5];
    r[5] = r[4] && (!chromaLineSkip || v[0] == 1'b0) && (!chromaPixSkip || h[0] == 1'b0);
    return r;
  endfunction

  always_ff @(posedge clk) begin
    logic run, fEnd;
    logic [5:0] e;
    run  = genEnA | genEnB;
    fEnd = run && mH >= mSh[0] - 1 && mV >= mSh[4] - 1;
    if (rst) begin
      mH <= '0; mV <= '0;
      for (int i = 0; i < 10; i++) mSh[i] <= pick(i);
      expFull <= ~polarity; expMask <= ~polarity; expOff <= ~polarity;
    end else begin
      e = hiOf(mH, mV) ~^ polarity;
      expFull <= run ? e : ~polarity;
      for (int i = 0; i < 6; i++) expMask[i] <= (run && MASK_B[i]) ? e[i] : ~polarity[i];
      expOff <= ~polarity;
      if (!run || fEnd) for (int i = 0; i < 10; i++) mSh[i] <= pick(i);
      if (!run) begin
        mH <= '0; mV <= '0;
      end else if (mH >= mSh[0] - 1) begin
        mH <= '0;
        mV <= (mV >= mSh[4] - 1) ? '0 : mV + 1'b1;
      end else begin
        mH <= mH + 1'b1;
      end
    end
  end

  int nChecks = 0;
  int nFails = 0;

  task automatic check6(string tag, string what, logic [5:0] act, logic [5:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // Each sampled cycle compares all three instances against the model
  task automatic runFor(string tag, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check6(tag, "full", oFull, expFull);
      check6({tag, " R12"}, "masked", oMask, expMask);
      check6({tag, " R2"}, "gen-off", oOff, expOff);
    end
  endtask

  task automatic tResetIdle();
    runFor("R2 reset", 4);
    rst = 1'b0;
    runFor("R2 idle", 20);
  endtask

  task automatic tBasic();
    genEnA = 1'b1;
    runFor("R1 R4 R5 R7 R13", 200);
  endtask

  task automatic tPolarity();
    polarity = 6'b010101;
    runFor("R3", 100);
    polarity = 6'b000000;
    runFor("R3", 100);
    polarity = 6'h3F;
  endtask

  task automatic tChroma();
    chromaLineSkip = 1'b1;
    runFor("R8", 100);
    chromaPixSkip = 1'b1;
    runFor("R8 R9", 100);
    chromaLineSkip = 1'b0;
    runFor("R9", 100);
    chromaPixSkip = 1'b0;
  endtask

  // R6: vBlank falls exactly one clock before hBlank at frame end
  task automatic tVblankEdge();
    logic prevVb = vb0;
    logic seen = 1'b0;
    for (int k = 0; k < 200 && !seen; k++) begin
      @(negedge clk);
      if (prevVb && !vb0) begin
        seen = 1'b1;
        check6("R6", "hBlank at vBlank fall", {5'b0, hb0}, 6'd1);
        @(negedge clk);
        check6("R6", "hBlank one clock later", {5'b0, hb0}, 6'd0);
      end
      prevVb = vb0;
    end
    check6("R6", "vBlank fall seen", {5'b0, seen}, 6'd1);
  endtask

  task automatic tAltEnable();
    genEnA = 1'b0;
    runFor("R2 drop", 10);
    genEnB = 1'b1;
    runFor("R2 alt enable", 120);
  endtask

  task automatic tSource();
    srcSel = 10'b0000000101;
    runFor("R10 R11", 200);
    srcSel = 10'b1111111111;
    runFor("R10", 200);
    srcSel = 10'b0000100010;
    runFor("R10", 150);
  endtask

  task automatic tMidFrame();
    srcSel = '1;
    runFor("R11", 37);
    hostTiming = packT(9, 6, 6, 8, 7, 4, 5, 6, 5, 8);
    runFor("R11 mid-frame", 160);
  endtask

  task automatic tDisable();
    runFor("R1", 23);
    genEnB = 1'b0;
    runFor("R2 stop", 8);
    hostTiming = packT(12, 8, 9, 11, 8, 5, 6, 7, 8, 11);
    genEnA = 1'b1;
    runFor("R1 R11 restart", 120);
  endtask

  initial begin
    hostTiming = packT(12, 8, 9, 11, 8, 5, 6, 7, 8, 11);
    detTiming  = packT(10, 6, 7, 9, 6, 4, 4, 5, 6, 9);
    tResetIdle();
    tBasic();
    tVblankEdge();
    tPolarity();
    tChroma();
    tAltEnable();
    tSource();
    tMidFrame();
    tVblankEdge();
    tDisable();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule